// File: doc/BRIEF.md
# Trace Buffer Fill Counter

This block keeps track of how much of a 64-line trace buffer holds valid data during a debug tracing session. Every trace store writes one 32-bit half of a 64-bit line, and each store strobe adds one to a 7-bit count. An odd count therefore means the newest line is only half written. A count of 2 means one complete line, and a count of 126 means 63 lines. When the count wraps from 127 to 0, a sticky full flag is raised, so a zero count with the flag set means all 64 lines are valid.

A session starts with an arm write. The arm write clears the count and the flag, captures the alignment mode and arms the counter. In end-aligned and mid-aligned sessions, counting goes on past the wrap. A non-zero count with the flag set then means the oldest entries have been overwritten. In a begin-aligned session, the wrap ends the session: the block issues a one-cycle arm-clear request and ignores further stores. A mid-aligned session also stops counting when an externally generated stop input is raised.

The count and the flag are cleared only by power-on reset. A system reset ends the session but leaves the count and the flag reporting what was stored before it. Reads of the trace buffer never change the count.

Top module: `tbuf_fill_ctr`

## Requirements
- R1: After power-on reset, the count is 0, the full flag is 0, the arm-clear request is 0 and the block is disarmed. Store strobes then have no effect until the first arm write.
- R2: An arm write (`arm_wr` high for one cycle) sets the count to 0 and the flag to 0 in the next cycle, captures `align_mode` and arms the block. A store strobe in the same cycle as an arm write is not counted.
- R3: While the block is armed and not stopped, each cycle with `half_store` high increments the count by exactly one in the next cycle. The value is in 32-bit half-line units, so count/2 is the number of full lines and bit 0 flags a half line.
- R4: A counted store at count 127 produces count 0 with the full flag set in the next cycle. The flag stays set until the next arm write or power-on reset.
- R5: In end-aligned or mid-aligned mode (mid not stopped), counting continues past the wrap. The full flag stays set while the count advances from 1 upward.
- R6: In begin-aligned mode, the wrapping store raises `arm_clr_req` for exactly one cycle, the cycle in which the count reads 0 with the flag set, and disarms the block. Later stores leave the count at 0 with the flag set until the next arm write.
- R7: In mid-aligned mode, `mid_stop` high while armed blocks any store in that same cycle and in every later cycle until the next arm write. In the other modes `mid_stop` has no effect.
- R8: Asserting `sys_rst_n` low leaves the count and the full flag unchanged and disarms the block, so stores after the reset do not change the count.
- R9: `tb_rd` has no effect on the count, the flag or the request.
- R10: Mode encoding on `align_mode` is 00 begin, 01 mid, 10 end, with 11 acting as end. Only the value present at the arm write matters; changes while armed are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears everything |
| sys_rst_n | input | 1 | Asynchronous active-low system reset; ends the session only |
| arm_wr | input | 1 | One-cycle strobe: arm bit written to one |
| half_store | input | 1 | One-cycle strobe: a 32-bit half line was stored |
| tb_rd | input | 1 | Trace buffer read strobe (no effect) |
| mid_stop | input | 1 | External stop condition for mid-aligned sessions |
| align_mode | input | 2 | Alignment mode: 00 begin, 01 mid, 10/11 end |
| fill_cnt | output | 7 | Valid data in half-line units |
| buf_full | output | 1 | Sticky flag set on count wrap |
| arm_clr_req | output | 1 | One-cycle request to clear the arm bit |

## Verification
The assertions assume that the strobes are synchronous to `clk` and that a store strobe means exactly one half line. They also assume that the count moves only through stores, arm writes and power-on reset. The stimulus drives every strobe on the falling edge and holds it for one full cycle. It releases resets on the falling edge and waits out the synchronizer stages before any strobe. The stimulus also sweeps every `align_mode` code well past the wrap, with reads, stop pulses and mode changes mixed in, so that each post-wrap path is reached from a known count.

// File: rtl/tbuf_fill_pkg.sv
package tbuf_fill_pkg;

  typedef enum logic [1:0] {
    ALN_BEGIN = 2'b00,
    ALN_MID   = 2'b01,
    ALN_END   = 2'b10
  } aln_e;

  // R10: 11 is folded onto the end-aligned behaviour
  function automatic aln_e aln_decode(input logic [1:0] raw);
    aln_e m;
    case (raw)
      2'b00:   m = ALN_BEGIN;
      2'b01:   m = ALN_MID;
      default: m = ALN_END;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tbuf_rst_sync.sv
module tbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tbuf_session_ctl.sv
module tbuf_session_ctl
  import tbuf_fill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_wr,
  input  logic       half_store,
  input  logic       mid_stop,
  input  logic [1:0] align_mode,
  input  logic       wrap_evt,
  output logic       store_en,
  output logic       arm_clr_req
);

  logic armed_q, armed_d;
  logic stop_q, stop_d;
  logic req_q, req_d;
  aln_e mode_q, mode_d;
  logic mid_halt;

  // R7: the stop blocks a store in the same cycle it is seen
  assign mid_halt = (mode_q == ALN_MID) && (stop_q || mid_stop);
  assign store_en = armed_q && half_store && !arm_wr && !mid_halt;

  always_comb begin
    armed_d = armed_q;
    stop_d  = stop_q;
    mode_d  = mode_q;
    req_d   = 1'b0;
    if (arm_wr) begin
      armed_d = 1'b1;
      stop_d  = 1'b0;
      mode_d  = aln_decode(align_mode);
    end else begin
      if (armed_q && (mode_q == ALN_MID) && mid_stop) begin
        stop_d = 1'b1;
      end
      // R6: begin-aligned session ends on the wrap
      if (wrap_evt && (mode_q == ALN_BEGIN)) begin
        armed_d = 1'b0;
        req_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      stop_q  <= 1'b0;
      req_q   <= 1'b0;
      mode_q  <= ALN_END;
    end else begin
      armed_q <= armed_d;
      stop_q  <= stop_d;
      req_q   <= req_d;
      mode_q  <= mode_d;
    end
  end

  assign arm_clr_req = req_q;

endmodule

// File: rtl/tbuf_fill_cnt.sv
module tbuf_fill_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             store_en,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             buf_full,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             cnt_ce;

  assign wrap_evt = store_en && (cnt_q == CNT_MAX);
  assign cnt_ce   = arm_wr || store_en;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (arm_wr) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (store_en) begin
      cnt_d = cnt_q + 1'b1;
      if (wrap_evt) begin
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign fill_cnt = cnt_q;
  assign buf_full = full_q;

endmodule

// File: rtl/tbuf_fill_ctr.sv
module tbuf_fill_ctr #(
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             arm_wr,
  input  logic             half_store,
  input  logic             tb_rd,
  input  logic             mid_stop,
  input  logic [1:0]       align_mode,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             buf_full,
  output logic             arm_clr_req
);

  logic cnt_rst_n;
  logic sess_arst_n;
  logic sess_rst_n;
  logic store_en;
  logic wrap_evt;
  logic unused_rd;

  // R9: reads are observed but never change any state
  assign unused_rd   = tb_rd;
  assign sess_arst_n = por_n && sys_rst_n;

  // R8: count domain sees power-on reset only
  tbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_cnt_rst (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (cnt_rst_n)
  );

  tbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_sess_rst (
    .clk    (clk),
    .arst_n (sess_arst_n),
    .srst_n (sess_rst_n)
  );

  tbuf_session_ctl u_sess (
    .clk         (clk),
    .rst_n       (sess_rst_n),
    .arm_wr      (arm_wr),
    .half_store  (half_store),
    .mid_stop    (mid_stop),
    .align_mode  (align_mode),
    .wrap_evt    (wrap_evt),
    .store_en    (store_en),
    .arm_clr_req (arm_clr_req)
  );

  tbuf_fill_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (cnt_rst_n),
    .arm_wr   (arm_wr),
    .store_en (store_en),
    .fill_cnt (fill_cnt),
    .buf_full (buf_full),
    .wrap_evt (wrap_evt)
  );

endmodule

// File: rtl/tbuf_fill_chk.sv
module tbuf_fill_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             por_n,
  input logic             arm_wr,
  input logic             half_store,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             buf_full,
  input logic             arm_clr_req
);

  // R2
  arm_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    arm_wr |=> (fill_cnt == '0) && !buf_full);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!arm_wr && !half_store) |=> ($stable(fill_cnt) && $stable(buf_full)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (half_store && !arm_wr) |=>
      ((fill_cnt == $past(fill_cnt)) || (fill_cnt == CNT_W'($past(fill_cnt) + 1'b1))));

  // R4
  full_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (buf_full && !arm_wr) |=> buf_full);

  // R4
  full_on_wrap_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(buf_full) |-> ((fill_cnt == '0) && ($past(fill_cnt) == {CNT_W{1'b1}})));

  // R6
  clr_req_state_chk: assert property (@(posedge clk) disable iff (!por_n)
    arm_clr_req |-> ((fill_cnt == '0) && buf_full));

  // R6
  clr_req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    arm_clr_req |=> !arm_clr_req);

endmodule

bind tbuf_fill_ctr tbuf_fill_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .arm_wr      (arm_wr),
  .half_store  (half_store),
  .fill_cnt    (fill_cnt),
  .buf_full    (buf_full),
  .arm_clr_req (arm_clr_req)
);

// File: tb/tbuf_fill_ctr_bench.sv
`timescale 1ns/1ps
module tbuf_fill_ctr_bench;

  logic       clk = 1'b0;
  logic       por_n;
  logic       sys_rst_n;
  logic       arm_wr;
  logic       half_store;
  logic       tb_rd;
  logic       mid_stop;
  logic [1:0] align_mode;
  logic [6:0] fill_cnt;
  logic       buf_full;
  logic       arm_clr_req;

  int checks = 0;
  int errors = 0;

  // bench-side expectations
  int m_cnt;
  bit m_full;
  bit m_armed;
  bit m_stop;
  bit m_clr;
  int m_mode; // 0 begin, 1 mid, 2 end

  always #10 clk = ~clk;

  tbuf_fill_ctr u_tbuf_fill_ctr (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .arm_wr      (arm_wr),
    .half_store  (half_store),
    .tb_rd       (tb_rd),
    .mid_stop    (mid_stop),
    .align_mode  (align_mode),
    .fill_cnt    (fill_cnt),
    .buf_full    (buf_full),
    .arm_clr_req (arm_clr_req)
  );

  task automatic check_all(input string req);
    checks++;
    if (fill_cnt !== 7'(m_cnt) || buf_full !== m_full || arm_clr_req !== m_clr) begin
      errors++;
      $display("FAIL %s: cnt=%0d full=%0b req=%0b expected cnt=%0d full=%0b req=%0b",
               req, fill_cnt, buf_full, arm_clr_req, m_cnt, m_full, m_clr);
    end
  endtask

  // one cycle: drive on the falling edge, sample 2 ns after the rising edge
  task automatic step(input bit a, input bit s, input bit r, input bit p,
                      input logic [1:0] m, input string req);
    @(negedge clk);
    arm_wr = a; half_store = s; tb_rd = r; mid_stop = p; align_mode = m;
    @(posedge clk);
    if (a) begin
      m_cnt = 0; m_full = 0; m_armed = 1; m_stop = 0; m_clr = 0;
      m_mode = (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    end else begin
      bit en;
      m_clr = 0;
      en = m_armed && s && !(m_mode == 1 && (m_stop || p));
      if (m_armed && m_mode == 1 && p) m_stop = 1;
      if (en) begin
        if (m_cnt == 127) begin
          m_cnt = 0; m_full = 1;
          if (m_mode == 0) begin m_armed = 0; m_clr = 1; end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
    #2;
    check_all(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'b10, req);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 0; sys_rst_n = 1; arm_wr = 0; half_store = 0; tb_rd = 0;
    mid_stop = 0; align_mode = 2'b00;
    m_cnt = 0; m_full = 0; m_armed = 0; m_stop = 0; m_clr = 0; m_mode = 2;
    repeat (3) @(negedge clk);
    por_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check_all("R1 reset state");
    // R1: stores before any arm are ignored
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 2'b10, "R1 disarmed store");

    // R3 R4 R5 R6 R10: sweep all mode codes well past the wrap
    for (int md = 0; md < 4; md++) begin
      step(1, 0, 0, 0, 2'(md), "R2 arm");
      for (int i = 0; i < 300; i++) begin
        // R10: scramble the mode input while armed; R9: reads on some cycles
        step(0, (i % 7) != 3, (i % 5) == 0, 0, 2'((md + i) % 4),
             md == 0 ? "R6 begin sweep" : md == 1 ? "R5 mid sweep" : "R5 end sweep");
      end
    end

    // R2: arm and store in the same cycle
    step(1, 0, 0, 0, 2'b10, "R2 arm");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 2'b10, "R3 count");
    step(1, 1, 0, 0, 2'b10, "R2 arm wins over store");

    // R7: mid stop, including a store in the stop cycle
    step(1, 0, 0, 0, 2'b01, "R2 arm mid");
    for (int i = 0; i < 11; i++) step(0, 1, 0, 0, 2'b01, "R3 mid count");
    step(0, 1, 0, 1, 2'b01, "R7 stop blocks same-cycle store");
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 2'b01, "R7 stays stopped");
    step(1, 0, 0, 0, 2'b01, "R7 rearm clears stop");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 2'b01, "R7 counting resumes");

    // R7: stop ignored in end and begin modes
    step(1, 0, 0, 0, 2'b11, "R2 arm end(11)");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 1, 2'b11, "R7 stop ignored end");
    step(1, 0, 0, 0, 2'b00, "R2 arm begin");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 1, 2'b00, "R7 stop ignored begin");

    // R9: reads alone leave state intact
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 2'b00, "R9 read no effect");

    // R8: system reset keeps the count, ends the session
    step(1, 0, 0, 0, 2'b10, "R2 arm end");
    for (int i = 0; i < 165; i++) step(0, 1, 0, 0, 2'b10, "R5 end past wrap");
    @(negedge clk);
    sys_rst_n = 0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1;
    m_armed = 0; m_stop = 0; m_clr = 0;
    repeat (3) @(negedge clk);
    #1;
    check_all("R8 count kept over system reset");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 2'b10, "R8 disarmed after system reset");

    // R1: power-on reset clears everything
    @(negedge clk);
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    m_cnt = 0; m_full = 0; m_armed = 0; m_stop = 0; m_clr = 0;
    repeat (3) @(negedge clk);
    #1;
    check_all("R1 power-on clears");
    idle(2, "R1 idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule